// File: doc/BRIEF.md
# Pipelined SPI Position and ADC Readout Slave

This block is an SPI slave that lets a host read an encoder's 24-bit interpolated position, or its most recent sine, cosine and zero-track ADC samples, through fixed 32-bit transactions. The first byte the host shifts in is a command byte, and a 3-bit read-mode field in that byte selects the data wanted. The answer does not come back in the same transaction. It is shifted out during the transaction that follows. The value is captured at the moment the chip select of that following transaction goes low, so the data is one frame old at most and never older.

The position input is sampled on every core clock. The ADC inputs are sampled only once per ADC refresh period, which is a fixed number of core cycles. A host that wants a steady stream of position values sends read-mode-0 commands back to back, and each transaction returns the position captured at its own start. The block also drives an enable for the incremental quadrature and commutation outputs. It holds that enable low while SPI-only operation is selected.

The SPI pins are brought into the core clock domain through two-flop synchronizers. The core clock therefore has to run at least four times faster than SCLK. The bus uses SPI mode 0: SCLK idles low, the host samples on the rising edge, and the slave shifts on the falling edge.

Top module: `enc_spi_readout`

## Requirements
- R1: A frame is the group of SCLK rising edges while `ss_n` is low. The first 8 bits on `mosi` form the command byte, MSB first, and the read mode is command bits [7:5].
- R2: The reply to a full frame is shifted out on `miso` during the next frame, MSB first, with one bit per SCLK period. Bits 31..24 are always zero and bits 23..0 carry the data.
- R3: Reply data is captured when `ss_n` falls at the start of the replying frame. An input change made before that fall is returned. A change made after it does not alter the reply in progress.
- R4: A read mode of 0 or 3 returns the 24-bit position.
- R5: Read mode 1 returns sine in data bits [23:12] and cosine in bits [11:0]. Read mode 2 returns the zero-track sample in bits [11:0], with bits [23:12] zero.
- R6: The ADC sample registers reload once every 16 core cycles. A reply returns the ADC input values whenever those inputs were held for at least 20 core cycles before `ss_n` fell.
- R7: The first frame after reset returns all zeros. So does the frame that follows a command with read mode 4 to 7.
- R8: If a frame has any bit count other than 32, the next frame returns all zeros.
- R9: `miso_oe` is high exactly while `ss_n` is low.
- R10: `incr_out_en` is 0 during reset. One core cycle after a clock edge it equals the inverse of the `spi_only_en` value sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pos_in | input | 24 | Live interpolated position |
| adc_sin | input | 12 | Sine ADC sample |
| adc_cos | input | 12 | Cosine ADC sample |
| adc_zero | input | 12 | Zero-track ADC sample |
| spi_only_en | input | 1 | Selects SPI-only operation |
| incr_out_en | output | 1 | Enable for the incremental outputs |
| sclk | input | 1 | SPI clock, mode 0 |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Host-to-slave data |
| miso | output | 1 | Slave-to-host data |
| miso_oe | output | 1 | Output enable for `miso` |

## Verification
The bench first checks that the reply lags its command by one frame. A design that answered within the same frame would return the current command's data one frame early, and it would return position data in the very first frame instead of zeros.

The position input is changed during each reply frame and again just before the next select fall. A design that captured the data too early would return the stale value. A design that failed to freeze its shift register once loaded would let the mid-frame change leak into the bits still to be sent.

Short frames and over-long frames are mixed with full frames, and so are all eight read-mode codes. A design that still honoured an aborted command would return real data where zeros are expected. So would a design that treated modes 4 to 7 as position reads.

// File: rtl/enc_spi_pkg.sv
// Package: shared constants for the SPI readout slave.
// Holds the read-mode field width and the code values the reply mux decodes.
package enc_spi_pkg;
    localparam int RM_W = 3;
    typedef logic [RM_W-1:0] rmode_t;

    localparam rmode_t RM_POS     = 3'd0;
    localparam rmode_t RM_SINCOS  = 3'd1;
    localparam rmode_t RM_ZERO    = 3'd2;
    localparam rmode_t RM_POS_ALT = 3'd3;
endpackage

// File: rtl/spi_pin_sync.sv
// Module: spi_pin_sync
// Brings SCLK, slave select and MOSI into the core clock domain through
// STAGES-deep flop chains, then derives one-cycle edge strobes.
// Assumes: the core clock is at least 4x SCLK, so no SCLK edge is missed.
// MOSI goes through the same depth as SCLK, so it stays aligned with sclk_rise.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic ss_n,
    input  logic mosi,
    output logic ss_act,
    output logic ss_fall,
    output logic ss_rise,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s
);
    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] IDLE = 3'b010; // {mosi, ss_n, sclk} idle levels

    logic [NPIN-1:0] pins_raw;
    logic [NPIN-1:0] pins_s;
    logic            sclk_d;
    logic            ss_d;

    assign pins_raw = {mosi, ss_n, sclk};

    genvar gp;
    generate
        for (gp = 0; gp < NPIN; gp++) begin : g_pin
            logic [STAGES-1:0] chain;
            // Shift the pin through its synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{IDLE[gp]}};
                else        chain <= {chain[STAGES-2:0], pins_raw[gp]};
            end
            assign pins_s[gp] = chain[STAGES-1];
        end
    endgenerate

    // Keep one cycle of history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            ss_d   <= 1'b1;
        end else begin
            sclk_d <= pins_s[0];
            ss_d   <= pins_s[1];
        end
    end

    assign ss_act    = ~pins_s[1];
    assign ss_fall   = ss_d & ~pins_s[1];
    assign ss_rise   = ~ss_d & pins_s[1];
    assign sclk_rise = pins_s[0] & ~sclk_d;
    assign sclk_fall = ~pins_s[0] & sclk_d;
    assign mosi_s    = pins_s[2];
endmodule

// File: rtl/spi_cmd_rx.sv
// Module: spi_cmd_rx
// Counts the bits in each frame and captures the command byte.
// When select rises it publishes the pending read request, which is marked
// valid only if the frame held exactly FRAME_BITS bits.
// Assumes: edge strobes come from spi_pin_sync.
module spi_cmd_rx
    import enc_spi_pkg::*;
#(
    parameter int FRAME_BITS = 32,
    parameter int CTRL_BITS  = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ss_act,
    input  logic   ss_fall,
    input  logic   ss_rise,
    input  logic   sclk_rise,
    input  logic   mosi_s,
    output logic   pend_valid,
    output rmode_t pend_mode
);
    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_CTRL = CNT_W'(CTRL_BITS - 1);

    logic [CNT_W-1:0]     bit_cnt;
    logic [CTRL_BITS-1:0] sh;
    logic [CTRL_BITS-1:0] ctrl_q;

    // Count received bits, saturating one past a full frame
    always_ff @(posedge clk) begin
        if (!rst_n)                    bit_cnt <= '0;
        else if (ss_fall)              bit_cnt <= '0;
        else if (ss_act && sclk_rise && bit_cnt != CNT_MAX)
                                       bit_cnt <= bit_cnt + 1'b1;
    end

    // Shift in MOSI and latch the command byte on its last bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            ctrl_q <= '0;
        end else if (ss_act && sclk_rise && !ss_fall) begin
            sh <= {sh[CTRL_BITS-2:0], mosi_s};
            if (bit_cnt == CNT_CTRL) ctrl_q <= {sh[CTRL_BITS-2:0], mosi_s};
        end
    end

    // Publish the request when the frame closes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_mode  <= RM_POS;
        end else if (ss_rise) begin
            pend_valid <= (bit_cnt == CNT_FULL);
            pend_mode  <= ctrl_q[CTRL_BITS-1 -: RM_W];
        end
    end

    // R8
    short_frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_rise && bit_cnt != CNT_FULL) |=> !pend_valid);

    // R1
    count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_fall |=> (bit_cnt == '0));
endmodule

// File: rtl/pos_adc_sample.sv
// Module: pos_adc_sample
// Registers the live position on every core clock. Reloads the three ADC
// sample registers once every ADC_DIV cycles, driven by a free-running divider.
// Assumes: the ADC inputs are quasi-static relative to the core clock.
module pos_adc_sample #(
    parameter int POS_W   = 24,
    parameter int ADC_W   = 12,
    parameter int ADC_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos_in,
    input  logic [ADC_W-1:0] adc_sin,
    input  logic [ADC_W-1:0] adc_cos,
    input  logic [ADC_W-1:0] adc_zero,
    output logic [POS_W-1:0] pos_q,
    output logic [ADC_W-1:0] sin_q,
    output logic [ADC_W-1:0] cos_q,
    output logic [ADC_W-1:0] zero_q
);
    localparam int DIV_W = (ADC_DIV > 1) ? $clog2(ADC_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(ADC_DIV - 1);

    logic [DIV_W-1:0] div_cnt;
    logic             adc_tick;

    // Track the position on every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_in;
    end

    // Divide the core clock down to the ADC refresh rate
    always_ff @(posedge clk) begin
        if (!rst_n)                  div_cnt <= '0;
        else if (div_cnt == DIV_LAST) div_cnt <= '0;
        else                          div_cnt <= div_cnt + 1'b1;
    end

    assign adc_tick = (div_cnt == DIV_LAST);

    // Refresh the ADC samples on each divider tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sin_q  <= '0;
            cos_q  <= '0;
            zero_q <= '0;
        end else if (adc_tick) begin
            sin_q  <= adc_sin;
            cos_q  <= adc_cos;
            zero_q <= adc_zero;
        end
    end

    // R6
    adc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_tick |=> ($stable(sin_q) && $stable(cos_q) && $stable(zero_q)));
endmodule

// File: rtl/spi_reply_tx.sv
// Module: spi_reply_tx
// Selects reply data from the pending request and loads it into the transmit
// shift register when select falls. It shifts one bit on each SCLK fall.
// Assumes: MISO is sampled by the host on SCLK rising edges (mode 0).
module spi_reply_tx
    import enc_spi_pkg::*;
#(
    parameter int FRAME_BITS = 32,
    parameter int POS_W      = 24,
    parameter int ADC_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ss_act,
    input  logic             ss_fall,
    input  logic             sclk_fall,
    input  logic             pend_valid,
    input  rmode_t           pend_mode,
    input  logic [POS_W-1:0] pos_q,
    input  logic [ADC_W-1:0] sin_q,
    input  logic [ADC_W-1:0] cos_q,
    input  logic [ADC_W-1:0] zero_q,
    output logic             miso_bit
);
    localparam int HDR_W = FRAME_BITS - POS_W;

    logic [POS_W-1:0]      reply;
    logic [FRAME_BITS-1:0] tx_sr;

    // Decode the pending read mode into reply data
    always_comb begin
        reply = '0;
        if (pend_valid) begin
            case (pend_mode)
                RM_POS, RM_POS_ALT: reply = pos_q;
                RM_SINCOS:          reply = (POS_W'(sin_q) << ADC_W) | POS_W'(cos_q);
                RM_ZERO:            reply = POS_W'(zero_q);
                default:            reply = '0;
            endcase
        end
    end

    // Snapshot on select fall, then shift on each SCLK fall
    always_ff @(posedge clk) begin
        if (!rst_n)                     tx_sr <= '0;
        else if (ss_fall)               tx_sr <= {{HDR_W{1'b0}}, reply};
        else if (ss_act && sclk_fall)   tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
    end

    assign miso_bit = tx_sr[FRAME_BITS-1];

    // R2
    header_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_fall |=> (tx_sr[FRAME_BITS-1 -: HDR_W] == '0));

    // R7
    invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_fall && (!pend_valid || pend_mode[RM_W-1])) |=> (tx_sr == '0));

    // R3
    frozen_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_act && !ss_fall && !sclk_fall) |=> $stable(tx_sr));
endmodule

// File: rtl/enc_spi_readout.sv
// Module: enc_spi_readout (top)
// An SPI slave that returns position or ADC data one frame after the request.
// It also gates the incremental-output enable while SPI-only operation is on.
// Assumes: core clock >= 4x SCLK, SPI mode 0, select idles high.
module enc_spi_readout
    import enc_spi_pkg::*;
#(
    parameter int FRAME_BITS  = 32,
    parameter int CTRL_BITS   = 8,
    parameter int POS_W       = 24,
    parameter int ADC_W       = 12,
    parameter int ADC_DIV     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos_in,
    input  logic [ADC_W-1:0] adc_sin,
    input  logic [ADC_W-1:0] adc_cos,
    input  logic [ADC_W-1:0] adc_zero,
    input  logic             spi_only_en,
    output logic             incr_out_en,
    input  logic             sclk,
    input  logic             ss_n,
    input  logic             mosi,
    output logic             miso,
    output logic             miso_oe
);
    logic   ss_act, ss_fall, ss_rise, sclk_rise, sclk_fall, mosi_s;
    logic   pend_valid;
    rmode_t pend_mode;
    logic [POS_W-1:0] pos_q;
    logic [ADC_W-1:0] sin_q, cos_q, zero_q;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
        .ss_act(ss_act), .ss_fall(ss_fall), .ss_rise(ss_rise),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s)
    );

    spi_cmd_rx #(.FRAME_BITS(FRAME_BITS), .CTRL_BITS(CTRL_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .ss_act(ss_act), .ss_fall(ss_fall),
        .ss_rise(ss_rise), .sclk_rise(sclk_rise), .mosi_s(mosi_s),
        .pend_valid(pend_valid), .pend_mode(pend_mode)
    );

    pos_adc_sample #(.POS_W(POS_W), .ADC_W(ADC_W), .ADC_DIV(ADC_DIV)) u_smp (
        .clk(clk), .rst_n(rst_n), .pos_in(pos_in), .adc_sin(adc_sin),
        .adc_cos(adc_cos), .adc_zero(adc_zero), .pos_q(pos_q),
        .sin_q(sin_q), .cos_q(cos_q), .zero_q(zero_q)
    );

    spi_reply_tx #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W), .ADC_W(ADC_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .ss_act(ss_act), .ss_fall(ss_fall),
        .sclk_fall(sclk_fall), .pend_valid(pend_valid), .pend_mode(pend_mode),
        .pos_q(pos_q), .sin_q(sin_q), .cos_q(cos_q), .zero_q(zero_q),
        .miso_bit(miso)
    );

    // Pad enable follows the select pin directly
    assign miso_oe = ~ss_n;

    // Gate the incremental outputs while SPI-only operation is selected
    always_ff @(posedge clk) begin
        if (!rst_n) incr_out_en <= 1'b0;
        else        incr_out_en <= ~spi_only_en;
    end

    // R10
    incr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_only_en |=> !incr_out_en);

    // R10
    incr_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_only_en |=> incr_out_en);
endmodule

// File: tb/enc_spi_readout_tb.sv
// Bench for enc_spi_readout: directed corner cases, then seeded random frames.
module enc_spi_readout_tb;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pos_in = '0;
    logic [11:0] adc_sin = '0, adc_cos = '0, adc_zero = '0;
    logic [11:0] nxt_sin = '0, nxt_cos = '0, nxt_zero = '0;
    logic        spi_only_en = 1'b1;
    logic        incr_out_en;
    logic        sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic        miso, miso_oe;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   prev_valid = 1'b0;
    logic [2:0] prev_mode = '0;
    int   seed_dummy;

    always #4 clk = ~clk;

    enc_spi_readout u_dut (
        .clk(clk), .rst_n(rst_n), .pos_in(pos_in), .adc_sin(adc_sin),
        .adc_cos(adc_cos), .adc_zero(adc_zero), .spi_only_en(spi_only_en),
        .incr_out_en(incr_out_en), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input bit v, input logic [2:0] m,
        input logic [23:0] p, input logic [11:0] s, input logic [11:0] c, input logic [11:0] z);
        if (!v) return 32'h0;
        case (m)
            3'd0, 3'd3: return {8'h00, p};
            3'd1:       return {8'h00, s, c};
            3'd2:       return {20'h0, z};
            default:    return 32'h0;
        endcase
    endfunction

    function automatic string tag(input bit v, input logic [2:0] m);
        if (!v) return "R7 R8 invalid/none";
        case (m)
            3'd0, 3'd3: return "R4 R3 R2 position";
            3'd1:       return "R5 R6 sin/cos";
            3'd2:       return "R5 R6 zero";
            default:    return "R7 unrecognized mode";
        endcase
    endfunction

    // One frame: nbits SCLK periods, command byte first; returns bits seen on MISO.
    // The position is disturbed mid-frame and the next ADC values are installed.
    task automatic xfer(input int nbits, input logic [7:0] ctrl, input logic [23:0] pos_val,
                        output logic [31:0] got);
        got = '0;
        pos_in = pos_val;
        @(negedge clk);
        ss_n = 1'b0;
        repeat (8) @(negedge clk);
        check("R9 oe active", {31'h0, miso_oe}, 32'h1);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 8) ? ctrl[7 - i] : 1'($urandom);
            repeat (HALF) @(negedge clk);
            got = {got[30:0], miso};
            sclk = 1'b1;
            if (i == 12) pos_in = 24'($urandom);
            if (i == 16) begin
                adc_sin = nxt_sin; adc_cos = nxt_cos; adc_zero = nxt_zero;
            end
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        ss_n = 1'b1;
        @(negedge clk);
        check("R9 oe idle", {31'h0, miso_oe}, 32'h0);
        repeat (8) @(negedge clk);
    endtask

    // Full-frame helper that checks the reply against the model.
    task automatic frame_chk(input int nbits, input logic [2:0] mode, input logic [23:0] pos_val);
        logic [31:0] got;
        logic [31:0] exp;
        string t;
        exp = model(prev_valid, prev_mode, pos_val, adc_sin, adc_cos, adc_zero);
        t = tag(prev_valid, prev_mode);
        xfer(nbits, {mode, 5'($urandom)}, pos_val, got);
        if (nbits == 32) check(t, got, exp);
        prev_valid = (nbits == 32);
        prev_mode  = mode;
        nxt_sin  = 12'($urandom);
        nxt_cos  = 12'($urandom);
        nxt_zero = 12'($urandom);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'h5EED1234);
        nxt_sin = 12'hA5C; nxt_cos = 12'h3B1; nxt_zero = 12'h7E2;
        adc_sin = 12'h123; adc_cos = 12'h456; adc_zero = 12'h789;
        repeat (5) @(negedge clk);
        check("R10 reset incr_out_en", {31'h0, incr_out_en}, 32'h0);
        check("R9 reset oe", {31'h0, miso_oe}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 gated", {31'h0, incr_out_en}, 32'h0);
        spi_only_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 open", {31'h0, incr_out_en}, 32'h1);
        spi_only_en = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 gated again", {31'h0, incr_out_en}, 32'h0);
        repeat (30) @(negedge clk);

        // Directed: first-frame zeros, each mode, lag by one frame (R1)
        frame_chk(32, 3'd0, 24'hABCDEF);
        frame_chk(32, 3'd3, 24'h123456);
        frame_chk(32, 3'd1, 24'hFEDCBA);
        frame_chk(32, 3'd2, 24'h000001);
        frame_chk(32, 3'd5, 24'hFFFFFF);
        frame_chk(32, 3'd0, 24'h800000);
        frame_chk(32, 3'd7, 24'h0F0F0F);
        frame_chk(32, 3'd0, 24'h55AA55);
        // Short and long frames drop the request (R8)
        frame_chk(16, 3'd0, 24'h111111);
        frame_chk(32, 3'd0, 24'h222222);
        frame_chk(40, 3'd3, 24'h333333);
        frame_chk(32, 3'd0, 24'h444444);
        frame_chk(32, 3'd0, 24'h555555);

        // Random mix of modes and frame lengths
        for (int k = 0; k < 110; k++) begin
            int sel;
            int nb;
            sel = int'($urandom_range(0, 9));
            nb  = (sel == 0) ? 20 : ((sel == 1) ? 33 : 32);
            frame_chk(nb, 3'($urandom), 24'($urandom));
        end
        frame_chk(32, 3'd0, 24'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule